// File: doc/BRIEF.md
# Lamp Fault Supervisor

This block decides, lamp by lamp, when the gate drivers of a fluorescent-lamp inverter channel may switch. Each channel waits for good supplies, then tries to strike its lamp, watches it while it runs, and reacts to faults. A fault either starts a bounded series of timed restrikes or latches at once. The supervisor only makes decisions. Comparators, gate pulse shaping and configuration storage sit outside it.

Every time base counts lamp cycles. A single-clock `lamp_tick` pulse marks each cycle, so all windows scale with the lamp frequency. One exception is the overcurrent response, which acts on any clock whether or not a tick is present. One registered fault flag gathers the latched faults of all channels. A scope bit selects what a latched fault does: stop only its own channel, or stop every channel through a shutdown request.

Top module: `lamp_fault_supervisor`

## Requirements
- R1: While `vdd_good` or `vinv_good` is low, every `gate_en` bit is low from the first clock edge after the flag drops.
- R2: When an enabled channel with good supplies starts a strike and `lamp_lit` stays low, `gate_en` stays high for 768 lamp ticks and then drops as a strike fault.
- R3: A tick with `lamp_lit` high during a strike moves the channel to run, and `gate_en` stays high.
- R4: In run, 256 consecutive ticks with `lamp_lit` low are an extinguish fault. Any tick with `lamp_lit` high restarts that count.
- R5: `over_v` high on 256 consecutive ticks during strike or run is an overvoltage fault. A shorter pulse has no effect.
- R6: With `oc_enable` high, `over_i` during strike or run latches the channel on the next clock, even with no tick present. No retry follows. With `oc_enable` low, `over_i` is ignored.
- R7: After a strike, extinguish or overvoltage fault, the channel holds `gate_en` low for 1024 ticks and then strikes again. If a restrike succeeds, the channel runs normally. After 15 failed restrikes (16 strikes in all), the channel latches.
- R8: With `retry_inhibit` high, the first strike, extinguish or overvoltage fault latches the channel at once.
- R9: `fault_o` (active high) rises one clock after a channel latches. It stays high with the channel off until a supply flag drops. That drop clears it and resets the restrike count, and the channel starts over once the supplies are good.
- R10: With `shut_all_mode` high, a latched fault raises `shut_all_req` and forces every `gate_en` bit low. With the bit low, the other channels keep running.
- R11: A channel whose `chan_en` bit is low never drives and never contributes to `fault_o`, whatever its comparator inputs are.
- R12: Strike, extinguish, overvoltage and wait counts advance only on clocks where `lamp_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lamp_tick | input | 1 | One-clock pulse per lamp cycle |
| vdd_good | input | 1 | Device supply above its lockout level |
| vinv_good | input | 1 | Inverter supply above its monitor threshold |
| chan_en | input | NCH | Per-channel enable from configuration |
| lamp_lit | input | NCH | Lamp current above the open-lamp level |
| over_i | input | NCH | Lamp overcurrent comparator |
| over_v | input | NCH | Overvoltage comparator |
| oc_enable | input | 1 | Enables the instant overcurrent latch |
| retry_inhibit | input | 1 | 1 = no automatic restrike |
| shut_all_mode | input | 1 | 1 = a latched fault stops all channels |
| gate_en | output | NCH | Gate-driver enable per channel |
| fault_o | output | 1 | Registered latched-fault flag |
| shut_all_req | output | 1 | Request to disable all channels |

## Verification
The bench measures run lengths exactly: 768 ticks of strike, 1024 ticks of wait, and 256 ticks each for extinguish and overvoltage. An off-by-one counter therefore shows up as a wrong count, not a late fault. Random lamp-off gaps and overvoltage pulses up to 255 ticks check that the qualification counters restart. A design that kept counting across a lit sample would drop the drive during those gaps. The bench also counts restrikes up to the latch, which catches a wrong retry bound. It holds the tick low during a strike and during an overcurrent event: a design that counted clocks would time out, and one that waited for a tick would miss the instant latch. Scope, disabled-channel and supply-recycle cases confirm that the latch clears only through a supply flag and that a masked channel stays silent.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  typedef enum logic [2:0] {
    ST_CHK    = 3'd0,
    ST_STRIKE = 3'd1,
    ST_RUN    = 3'd2,
    ST_WAIT   = 3'd3,
    ST_LATCH  = 3'd4
  } lfs_state_t;

  function automatic int lfs_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lfs_window.sv
module lfs_window #(
  parameter int LEN = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  input  logic cond,
  output logic done
);
  localparam int WW = $clog2(LEN + 1);
  localparam logic [WW-1:0] LIM = WW'(LEN - 1);

  logic [WW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !cond) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = (cnt_q == LIM) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = !clr && cond && tick && (cnt_q == LIM);

  // R5: qualification count never exceeds its window
  p_win_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

endmodule

// File: rtl/lfs_chan.sv
module lfs_chan
  import lfs_pkg::*;
#(
  parameter int STRIKE_CYC = 768,
  parameter int EXT_CYC    = 256,
  parameter int OV_CYC     = 256,
  parameter int WAIT_CYC   = 1024,
  parameter int MAX_TRY    = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sup_ok,
  input  logic kill,
  input  logic en,
  input  logic lamp_on,
  input  logic oc,
  input  logic ov,
  input  logic oc_en,
  input  logic retry_off,
  output logic drive_o,
  output logic latched_o
);
  localparam int CW = $clog2(lfs_max3(STRIKE_CYC, EXT_CYC, WAIT_CYC) + 1);
  localparam int TW = $clog2(MAX_TRY + 1);
  localparam logic [CW-1:0] STRIKE_LIM = CW'(STRIKE_CYC - 1);
  localparam logic [CW-1:0] EXT_LIM    = CW'(EXT_CYC - 1);
  localparam logic [CW-1:0] WAIT_LIM   = CW'(WAIT_CYC - 1);
  localparam logic [TW-1:0] TRY_LIM    = TW'(MAX_TRY);

  lfs_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] try_q, try_d;
  logic          active, ov_hit, go_fault;

  assign active = (st_q == ST_STRIKE) || (st_q == ST_RUN);

  lfs_window #(.LEN(OV_CYC)) u_ovwin (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .clr   (!active),
    .cond  (ov),
    .done  (ov_hit)
  );

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    try_d    = try_q;
    go_fault = 1'b0;
    if (!sup_ok || !en) begin
      st_d  = ST_CHK;
      cnt_d = '0;
      try_d = '0;
    end else begin
      unique case (st_q)
        ST_CHK: begin
          cnt_d = '0;
          try_d = '0;
          if (!kill) st_d = ST_STRIKE;
        end
        ST_STRIKE, ST_RUN: begin
          if (kill) begin
            st_d  = ST_CHK;
            cnt_d = '0;
          end else if (oc && oc_en) begin
            st_d = ST_LATCH;
          end else if (ov_hit) begin
            go_fault = 1'b1;
          end else if (tick) begin
            if (lamp_on) begin
              st_d  = ST_RUN;
              cnt_d = '0;
            end else if (cnt_q == ((st_q == ST_STRIKE) ? STRIKE_LIM : EXT_LIM)) begin
              go_fault = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (kill) begin
            st_d  = ST_CHK;
            cnt_d = '0;
          end else if (tick) begin
            if (cnt_q == WAIT_LIM) begin
              st_d  = ST_STRIKE;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_LATCH: st_d = ST_LATCH;
        default:  st_d = ST_CHK;
      endcase
      if (go_fault) begin
        cnt_d = '0;
        if (retry_off || (try_q == TRY_LIM)) begin
          st_d = ST_LATCH;
        end else begin
          st_d  = ST_WAIT;
          try_d = try_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_CHK;
      cnt_q <= '0;
      try_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      try_q <= try_d;
    end
  end

  assign drive_o   = active && !kill;
  assign latched_o = (st_q == ST_LATCH) && en;

  // R1: a missing supply turns the drive off at the next edge
  p_supply_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |=> !drive_o);

  // R6: enabled overcurrent while active latches at the next edge
  p_oc_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (oc && oc_en && en && sup_ok && !kill && active) |=> latched_o);

  // R7: the wait state only leaves towards a restrike or a supply check
  p_wait_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |=> (st_q == ST_WAIT || st_q == ST_STRIKE || st_q == ST_CHK));

  // R9: a latch persists while supplies and enable stay up
  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LATCH && sup_ok && en) |=> (st_q == ST_LATCH));

  // R11: a disabled channel neither drives nor reports
  p_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!drive_o && !latched_o));

endmodule

// File: rtl/lfs_fault_flag.sv
module lfs_fault_flag #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] latched,
  input  logic           scope_all,
  output logic           fault_o,
  output logic           kill_o
);
  logic fault_q, fault_d;

  assign fault_d = |latched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign fault_o = fault_q;
  assign kill_o  = scope_all && fault_q;

  // R9: any latched channel shows on the flag one clock later
  p_flag_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|latched) |=> fault_o);

endmodule

// File: rtl/lamp_fault_supervisor.sv
module lamp_fault_supervisor #(
  parameter int NCH        = 4,
  parameter int STRIKE_CYC = 768,
  parameter int EXT_CYC    = 256,
  parameter int OV_CYC     = 256,
  parameter int WAIT_CYC   = 1024,
  parameter int MAX_TRY    = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lamp_tick,
  input  logic           vdd_good,
  input  logic           vinv_good,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] lamp_lit,
  input  logic [NCH-1:0] over_i,
  input  logic [NCH-1:0] over_v,
  input  logic           oc_enable,
  input  logic           retry_inhibit,
  input  logic           shut_all_mode,
  output logic [NCH-1:0] gate_en,
  output logic           fault_o,
  output logic           shut_all_req
);
  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic           sup_ok;
  logic           kill;
  logic [NCH-1:0] latched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign sup_ok = vdd_good && vinv_good;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    lfs_chan #(
      .STRIKE_CYC (STRIKE_CYC),
      .EXT_CYC    (EXT_CYC),
      .OV_CYC     (OV_CYC),
      .WAIT_CYC   (WAIT_CYC),
      .MAX_TRY    (MAX_TRY)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .tick      (lamp_tick),
      .sup_ok    (sup_ok),
      .kill      (kill),
      .en        (chan_en[g]),
      .lamp_on   (lamp_lit[g]),
      .oc        (over_i[g]),
      .ov        (over_v[g]),
      .oc_en     (oc_enable),
      .retry_off (retry_inhibit),
      .drive_o   (gate_en[g]),
      .latched_o (latched[g])
    );
  end

  lfs_fault_flag #(.NCH(NCH)) u_flag (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .latched   (latched),
    .scope_all (shut_all_mode),
    .fault_o   (fault_o),
    .kill_o    (kill)
  );

  assign shut_all_req = kill;

  // R10: a device-wide shutdown request leaves no gate enabled
  p_scope_off_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    shut_all_req |-> (gate_en == '0));

endmodule

// File: tb/lamp_fault_supervisor_test.sv
module lamp_fault_supervisor_test;
  localparam int NCH = 4;
  localparam int STRIKE_CYC = 768;
  localparam int EXT_CYC = 256;
  localparam int OV_CYC = 256;
  localparam int WAIT_CYC = 1024;
  localparam int MAX_TRY = 15;

  logic clk = 1'b0;
  logic rst_n, lamp_tick, vdd_good, vinv_good, oc_enable, retry_inhibit, shut_all_mode;
  logic [NCH-1:0] chan_en, lamp_lit, over_i, over_v, gate_en;
  logic fault_o, shut_all_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lamp_fault_supervisor #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .lamp_tick(lamp_tick), .vdd_good(vdd_good),
    .vinv_good(vinv_good), .chan_en(chan_en), .lamp_lit(lamp_lit),
    .over_i(over_i), .over_v(over_v), .oc_enable(oc_enable),
    .retry_inhibit(retry_inhibit), .shut_all_mode(shut_all_mode),
    .gate_en(gate_en), .fault_o(fault_o), .shut_all_req(shut_all_req));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // counts falling clock edges until gate_en[ch] reaches lvl
  task automatic run_len(input int ch, input logic lvl, input int lim, output int n);
    n = 0;
    while (gate_en[ch] !== lvl && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic cycles(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic supply_cycle();
    vinv_good = 1'b0;
    cycles(3);
    chk("R9 flag cleared by supply drop", int'(fault_o), 0);
    vinv_good = 1'b1;
  endtask

  function automatic int gap_survives(input int gap);
    return (gap < EXT_CYC && gap < OV_CYC) ? 1 : 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, bad, rises, gap;
    logic prev;
    void'($urandom(32'd2718));
    rst_n = 1'b0; lamp_tick = 1'b1; vdd_good = 1'b0; vinv_good = 1'b0;
    oc_enable = 1'b1; retry_inhibit = 1'b0; shut_all_mode = 1'b0;
    chan_en = 4'b0001; lamp_lit = '0; over_i = '0; over_v = '0;
    cycles(5);
    rst_n = 1'b1;
    cycles(5);
    chk("R1 reset gates", int'(gate_en), 0);
    chk("R9 reset flag", int'(fault_o), 0);
    chk("R10 reset request", int'(shut_all_req), 0);

    // R1: one supply good is not enough
    vdd_good = 1'b1;
    bad = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (gate_en != 0) bad++; end
    chk("R1 inverter supply low", bad, 0);

    // R2 strike timeout, R7 wait length, R11 masked channels silent
    vinv_good = 1'b1;
    run_len(0, 1'b1, 10, n);
    chk("R1 start after supplies good", n, 1);
    run_len(0, 1'b0, 5000, n);
    chk("R2 strike window", n, STRIKE_CYC);
    chk("R11 masked channels idle", int'(gate_en[3:1]), 0);
    run_len(0, 1'b1, 5000, n);
    chk("R7 wait window", n, WAIT_CYC);
    lamp_lit[0] = 1'b1;
    bad = 0;
    for (int i = 0; i < 2000; i++) begin @(negedge clk); if (!gate_en[0] || fault_o) bad++; end
    chk("R3 retry strike succeeds and runs", bad, 0);

    // R4/R5: random gaps and pulses below the windows
    bad = 0;
    for (int it = 0; it < 25; it++) begin
      gap = (it == 0) ? EXT_CYC - 1 : int'($urandom_range(1, EXT_CYC - 1));
      lamp_lit[0] = 1'b0; over_v[0] = 1'b1;
      for (int i = 0; i < gap; i++) begin
        @(negedge clk);
        if (int'(gate_en[0]) != gap_survives(gap)) bad++;
      end
      lamp_lit[0] = 1'b1; over_v[0] = 1'b0;
      cycles(int'($urandom_range(1, 3)));
      if (int'(gate_en[0]) != 1) bad++;
    end
    chk("R4 R5 short gaps and pulses ignored", bad, 0);

    // R4: full extinguish window
    lamp_lit[0] = 1'b0;
    run_len(0, 1'b0, 5000, n);
    chk("R4 extinguish window", n, EXT_CYC);
    lamp_lit[0] = 1'b1;
    run_len(0, 1'b1, 5000, n);
    chk("R7 restrike after extinguish", n, WAIT_CYC);

    // R5: full overvoltage window
    cycles(2);
    over_v[0] = 1'b1;
    run_len(0, 1'b0, 5000, n);
    chk("R5 overvoltage window", n, OV_CYC);
    over_v[0] = 1'b0;
    run_len(0, 1'b1, 5000, n);
    chk("R7 restrike after overvoltage", n, WAIT_CYC);

    // R6: overcurrent ignored when disabled, instant when enabled
    cycles(2);
    oc_enable = 1'b0; over_i[0] = 1'b1;
    bad = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (!gate_en[0] || fault_o) bad++; end
    chk("R6 overcurrent masked", bad, 0);
    lamp_tick = 1'b0; oc_enable = 1'b1;
    @(negedge clk);
    chk("R6 instant overcurrent off", int'(gate_en[0]), 0);
    chk("R9 flag registered one clock later", int'(fault_o), 0);
    @(negedge clk);
    chk("R9 flag set", int'(fault_o), 1);
    over_i[0] = 1'b0; lamp_tick = 1'b1;
    bad = 0;
    for (int i = 0; i < 1500; i++) begin @(negedge clk); if (gate_en[0] || !fault_o) bad++; end
    chk("R6 R9 no retry, latch holds", bad, 0);
    supply_cycle();
    run_len(0, 1'b1, 10, n);
    chk("R9 restart after supply cycle", n, 1);

    // R1 in run, then R12 tick gating
    cycles(3);
    vdd_good = 1'b0;
    @(negedge clk);
    chk("R1 device supply drop", int'(gate_en[0]), 0);
    lamp_tick = 1'b0; lamp_lit[0] = 1'b0;
    vdd_good = 1'b1;
    run_len(0, 1'b1, 10, n);
    bad = 0;
    for (int i = 0; i < 3000; i++) begin @(negedge clk); if (!gate_en[0]) bad++; end
    chk("R12 no tick no timeout", bad, 0);
    lamp_tick = 1'b1;
    run_len(0, 1'b0, 5000, n);
    chk("R12 count resumes with ticks", n, STRIKE_CYC);

    // R7: restrike bound
    rises = 0; prev = gate_en[0];
    for (int i = 0; i < 40000 && !fault_o; i++) begin
      @(negedge clk);
      if (gate_en[0] && !prev) rises++;
      prev = gate_en[0];
    end
    chk("R7 restrikes before latch", rises, MAX_TRY);
    chk("R7 latched after exhaustion", int'(fault_o), 1);

    // R8: retry inhibit
    retry_inhibit = 1'b1;
    supply_cycle();
    run_len(0, 1'b1, 10, n);
    run_len(0, 1'b0, 5000, n);
    chk("R8 strike window", n, STRIKE_CYC);
    cycles(2);
    chk("R8 immediate latch", int'(fault_o), 1);
    bad = 0;
    for (int i = 0; i < 1500; i++) begin @(negedge clk); if (gate_en[0]) bad++; end
    chk("R8 no restrike", bad, 0);
    retry_inhibit = 1'b0;

    // R10: fault scope
    chan_en = 4'b0011; lamp_lit = 4'b0011;
    supply_cycle();
    cycles(5);
    chk("R10 both running", int'(gate_en), 3);
    over_i[0] = 1'b1;
    cycles(3);
    chk("R10 local scope other runs", int'(gate_en), 2);
    chk("R10 local scope no request", int'(shut_all_req), 0);
    over_i[0] = 1'b0;
    shut_all_mode = 1'b1;
    supply_cycle();
    cycles(5);
    over_i[0] = 1'b1;
    cycles(3);
    chk("R10 global request", int'(shut_all_req), 1);
    chk("R10 global gates off", int'(gate_en), 0);
    over_i[0] = 1'b0;
    bad = 0;
    for (int i = 0; i < 500; i++) begin @(negedge clk); if (gate_en != 0) bad++; end
    chk("R10 global stays off", bad, 0);
    shut_all_mode = 1'b0;

    // R11: all channels masked, comparators screaming
    chan_en = '0; lamp_lit = '0; over_i = '1; over_v = '1;
    supply_cycle();
    bad = 0;
    for (int i = 0; i < 2000; i++) begin @(negedge clk); if (gate_en != 0 || fault_o) bad++; end
    chk("R11 masked never drives or faults", bad, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule